// File: doc/BRIEF.md
# Saturating Doubling Widening Multiply Unit

This unit is one SIMD execution lane group. It takes two 128-bit operand vectors and a set of already-decoded instruction fields. It selects one indexed element from the second operand and multiplies it by each chosen element of the first operand. Each product is doubled and then saturated to twice the source element width. The widened lanes are packed into the result.

Two element sizes are legal: 16-bit and 32-bit. The index bits are read differently for each size, and the unit also returns the register number of the second operand. In vector mode it works on either the lower or the upper 64-bit half of the first operand. In scalar mode it works on element 0 only. The unit flags encodings it cannot execute and keeps a sticky saturation flag, which a separate synchronous input clears.

A transfer uses a valid/ready handshake. The result is registered and appears on the clock edge that follows acceptance.

Top module: `sdm_unit`

## Requirements
- R1: `size_sel` = 01 selects 16-bit elements and 10 selects 32-bit elements. Both 00 and 11 give `out_undef`=1 with `out_data`=0 and `out_reg`=0, and they leave `sat_flag` unchanged.
- R2: For 16-bit elements the index is {idx_hi, idx_mid, idx_lo} (idx_hi is the MSB, range 0..7), and it selects `op_b[16*idx +: 16]`. The register number is {0, breg_lo}.
- R3: For 32-bit elements the index is {idx_hi, idx_mid} (range 0..3), and it selects `op_b[32*idx +: 32]`. The register number is {idx_lo, breg_lo}.
- R4: In vector mode the source is `op_a[63:0]` when `upper_half`=0 and `op_a[127:64]` when `upper_half`=1. Source element e (4 lanes of 16 bits or 2 lanes of 32 bits) drives result lane e, and each result lane is 2×esize bits wide.
- R5: Each result lane equals 2×a×b on signed values, saturated to the signed range of 2×esize bits.
- R6: When both inputs hold the most negative source value, the lane gives the most positive 2×esize-bit value and the other lanes are unaffected. No other input pair saturates.
- R7: Scalar mode processes only `op_a[esize-1:0]`, whatever the value of `upper_half`. Result bits at and above 2×esize are zero.
- R8: `sat_flag` is set when an accepted legal operation saturates in any active lane. It stays set until `sat_clear` is high at a clock edge. If a saturating operation is accepted in the same cycle as a clear, the set wins.
- R9: `in_ready` = !out_valid || out_ready. An accepted operation appears on the `out_*` ports with `out_valid`=1 after the next rising edge. While `out_valid`=1 and `out_ready`=0, the outputs hold.
- R10: After reset, `out_valid`=0, `sat_flag`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector (indexed) |
| size_sel | input | 2 | Element size code |
| upper_half | input | 1 | Use upper 64 bits of op_a in vector mode |
| idx_hi | input | 1 | Index field, high bit |
| idx_mid | input | 1 | Index field, middle bit |
| idx_lo | input | 1 | Index low bit (16-bit) or register bank bit (32-bit) |
| breg_lo | input | 4 | Low four bits of second operand register number |
| scalar_mode | input | 1 | 1 = single element, 0 = vector |
| sat_clear | input | 1 | Synchronous clear of sat_flag |
| out_ready | input | 1 | Consumer takes the result |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Packed widened result |
| out_reg | output | 5 | Second operand register number |
| out_undef | output | 1 | Encoding not executable |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Every result, register number, undefined indication and flag update is due on the rising edge after the cycle in which `in_valid` and `in_ready` are both high. Results therefore arrive in acceptance order, and a queue of expected items keeps them in step without counting cycles. The monitor samples one nanosecond after each falling edge. It pops an item only when `out_valid` and `out_ready` are both high, which is the cycle in which the result leaves. The expected flag travels inside each item, so every result also checks the flag state after that edge.

// File: rtl/sdm_pkg.sv
// Package: shared encodings for the saturating doubling multiply unit.
// Assumes: only the two size codes below are executable.
package sdm_pkg;
    typedef enum logic [1:0] {
        SZ_RSV_LO = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_WORD   = 2'b10,
        SZ_RSV_HI = 2'b11
    } sdm_size_e;
endpackage

// File: rtl/sdm_index_decode.sv
// Module: sdm_index_decode
// Decodes element size, element index and second-operand register number.
// Assumes: fields are stable while presented; output is purely combinational.
module sdm_index_decode
    import sdm_pkg::*;
(
    input  logic [1:0] size_sel,
    input  logic       idx_hi,
    input  logic       idx_mid,
    input  logic       idx_lo,
    input  logic [3:0] breg_lo,
    output logic       is_half,
    output logic       undef,
    output logic [2:0] elem_idx,
    output logic [4:0] reg_num
);
    // Size-dependent interpretation of index bits and register bank bit.
    always_comb begin
        is_half  = 1'b0;
        undef    = 1'b0;
        elem_idx = '0;
        reg_num  = '0;
        case (sdm_size_e'(size_sel))
            SZ_HALF: begin
                is_half  = 1'b1;
                elem_idx = {idx_hi, idx_mid, idx_lo};
                reg_num  = {1'b0, breg_lo};
            end
            SZ_WORD: begin
                elem_idx = {1'b0, idx_hi, idx_mid};
                reg_num  = {idx_lo, breg_lo};
            end
            default: undef = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdm_operand_select.sv
// Module: sdm_operand_select
// Picks the first-operand half and the indexed second-operand element.
// Assumes: scalar mode always uses the lower half (element 0 sits there).
module sdm_operand_select #(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic                upper_half,
    input  logic                scalar_mode,
    input  logic [2:0]          elem_idx,
    output logic [DATA_W/2-1:0] a_half,
    output logic [15:0]         b_half,
    output logic [31:0]         b_word
);
    localparam int HALF_W = DATA_W / 2;

    // Half select: upper half only in vector mode with upper_half set.
    always_comb begin
        a_half = (upper_half && !scalar_mode) ? op_a[DATA_W-1:HALF_W] : op_a[HALF_W-1:0];
    end

    // Indexed element of the second operand for both element sizes.
    always_comb begin
        b_half = op_b[16*elem_idx +: 16];
        b_word = op_b[32*elem_idx[1:0] +: 32];
    end
endmodule

// File: rtl/sdm_sat_lane.sv
// Module: sdm_sat_lane
// One lane: signed a*b, doubled, saturated to 2*ESIZE bits.
// Assumes: two's complement inputs; combinational.
module sdm_sat_lane #(
    parameter int ESIZE = 16
) (
    input  logic [ESIZE-1:0]   a,
    input  logic [ESIZE-1:0]   b,
    output logic [2*ESIZE-1:0] res,
    output logic               sat
);
    localparam int RW = 2 * ESIZE;
    localparam logic [ESIZE-1:0] MIN_IN = {1'b1, {(ESIZE-1){1'b0}}};

    logic signed [RW-1:0] prod;
    logic signed [RW:0]   dbl;

    // Full-width signed product, then doubled with one guard bit.
    always_comb begin
        prod = $signed(a) * $signed(b);
        dbl  = {prod, 1'b0};
    end

    // Saturate when the guard bit disagrees with the result sign.
    always_comb begin
        sat = dbl[RW] ^ dbl[RW-1];
        if (sat) res = dbl[RW] ? {1'b1, {(RW-1){1'b0}}} : {1'b0, {(RW-1){1'b1}}};
        else     res = dbl[RW-1:0];
    end

    // R6: only the most-negative pair may saturate.
    always_comb begin
        a_r6_min_pair: assert (!sat || (a == MIN_IN && b == MIN_IN));
    end
endmodule

// File: rtl/sdm_unit.sv
// Module: sdm_unit (top)
// Indexed saturating doubling widening multiply with handshake and sticky flag.
// Assumes: synchronous active-low reset; one operation in flight at a time.
module sdm_unit #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        size_sel,
    input  logic              upper_half,
    input  logic              idx_hi,
    input  logic              idx_mid,
    input  logic              idx_lo,
    input  logic [3:0]        breg_lo,
    input  logic              scalar_mode,
    input  logic              sat_clear,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [4:0]        out_reg,
    output logic              out_undef,
    output logic              sat_flag
);
    localparam int HALF_W = DATA_W / 2;
    localparam int N_HALF = HALF_W / 16;
    localparam int N_WORD = HALF_W / 32;

    logic              is_half, undef;
    logic [2:0]        elem_idx;
    logic [4:0]        reg_num;
    logic [HALF_W-1:0] a_half;
    logic [15:0]       b_half;
    logic [31:0]       b_word;
    logic [N_HALF-1:0] sat_h, en_h;
    logic [N_WORD-1:0] sat_w, en_w;
    logic [DATA_W-1:0] vec_h, vec_w, next_data;
    logic              next_sat, accept;
    logic              scalar_q, half_q;

    sdm_index_decode i_decode (
        .size_sel (size_sel),
        .idx_hi   (idx_hi),
        .idx_mid  (idx_mid),
        .idx_lo   (idx_lo),
        .breg_lo  (breg_lo),
        .is_half  (is_half),
        .undef    (undef),
        .elem_idx (elem_idx),
        .reg_num  (reg_num)
    );

    sdm_operand_select #(.DATA_W(DATA_W)) i_select (
        .op_a        (op_a),
        .op_b        (op_b),
        .upper_half  (upper_half),
        .scalar_mode (scalar_mode),
        .elem_idx    (elem_idx),
        .a_half      (a_half),
        .b_half      (b_half),
        .b_word      (b_word)
    );

    generate
        for (genvar g = 0; g < N_HALF; g++) begin : g_half
            logic [31:0] r;
            sdm_sat_lane #(.ESIZE(16)) i_lane (
                .a (a_half[16*g +: 16]), .b (b_half), .res (r), .sat (sat_h[g])
            );
            assign en_h[g]          = !scalar_mode || (g == 0);
            assign vec_h[32*g +: 32] = en_h[g] ? r : 32'd0;
        end
        for (genvar g = 0; g < N_WORD; g++) begin : g_word
            logic [63:0] r;
            sdm_sat_lane #(.ESIZE(32)) i_lane (
                .a (a_half[32*g +: 32]), .b (b_word), .res (r), .sat (sat_w[g])
            );
            assign en_w[g]          = !scalar_mode || (g == 0);
            assign vec_w[64*g +: 64] = en_w[g] ? r : 64'd0;
        end
    endgenerate

    // Result and saturation of the operation on the inputs.
    always_comb begin
        if (undef) begin
            next_data = '0;
            next_sat  = 1'b0;
        end else if (is_half) begin
            next_data = vec_h;
            next_sat  = |(sat_h & en_h);
        end else begin
            next_data = vec_w;
            next_sat  = |(sat_w & en_w);
        end
    end

    // Handshake: accept when the output register is free or being drained.
    always_comb begin
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
    end

    // Output register load and drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_reg   <= '0;
            out_undef <= 1'b0;
            scalar_q  <= 1'b0;
            half_q    <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= next_data;
            out_reg   <= undef ? 5'd0 : reg_num;
            out_undef <= undef;
            scalar_q  <= scalar_mode;
            half_q    <= is_half;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Sticky saturation flag; a new saturation beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sat_flag <= 1'b0;
        else if (accept && next_sat) sat_flag <= 1'b1;
        else if (sat_clear)         sat_flag <= 1'b0;
    end

    a_r1_undef_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_undef |-> out_data == '0 && out_reg == 5'd0);
    a_r2_low_bank: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_undef && half_q |-> !out_reg[4]);
    a_r7_scalar_half_upper: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && scalar_q && half_q |-> out_data[DATA_W-1:32] == '0);
    a_r7_scalar_word_upper: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && scalar_q && !half_q |-> out_data[DATA_W-1:64] == '0);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag && !sat_clear |=> sat_flag);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_reg));
endmodule

// File: tb/test_sdm_unit.sv
module test_sdm_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_ready;
    logic [127:0] op_a = '0, op_b = '0;
    logic [1:0]   size_sel = 2'b01;
    logic         upper_half = 0, idx_hi = 0, idx_mid = 0, idx_lo = 0;
    logic [3:0]   breg_lo = '0;
    logic         scalar_mode = 0, sat_clear = 0, out_ready = 1;
    logic         out_valid, out_undef, sat_flag;
    logic [127:0] out_data;
    logic [4:0]   out_reg;

    always #2.5 clk = ~clk;

    sdm_unit i_sdm_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_a(op_a), .op_b(op_b), .size_sel(size_sel), .upper_half(upper_half),
        .idx_hi(idx_hi), .idx_mid(idx_mid), .idx_lo(idx_lo), .breg_lo(breg_lo),
        .scalar_mode(scalar_mode), .sat_clear(sat_clear), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_reg(out_reg),
        .out_undef(out_undef), .sat_flag(sat_flag)
    );

    typedef struct {
        logic [127:0] data;
        logic [4:0]   rn;
        logic         undef;
        logic         sat;
        logic         flag;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0;
    logic flag_m = 1'b0;
    bit   done = 0;

    function automatic exp_t model(input logic [127:0] a, input logic [127:0] b,
                                   input logic [1:0] sz, input logic uh, input logic h,
                                   input logic md, input logic lo, input logic [3:0] rl,
                                   input logic sc);
        exp_t r;
        int es, idx, n, base;
        logic signed [66:0] x, y, pr, mx, mn;
        logic [63:0] lv;
        r.data = '0; r.rn = '0; r.undef = 0; r.sat = 0; r.flag = 0; r.tag = "";
        if (sz != 2'b01 && sz != 2'b10) begin
            r.undef = 1;
            return r;
        end
        es   = (sz == 2'b01) ? 16 : 32;
        idx  = (es == 16) ? int'({h, md, lo}) : int'({h, md});
        r.rn = (es == 16) ? {1'b0, rl} : {lo, rl};
        n    = sc ? 1 : 64 / es;
        base = (uh && !sc) ? 64 : 0;
        mx = (67'sd1 <<< (2*es-1)) - 67'sd1;
        mn = -(67'sd1 <<< (2*es-1));
        for (int e = 0; e < n; e++) begin
            if (es == 16) begin
                x = 67'($signed(a[base+e*16 +: 16]));
                y = 67'($signed(b[idx*16 +: 16]));
            end else begin
                x = 67'($signed(a[base+e*32 +: 32]));
                y = 67'($signed(b[idx*32 +: 32]));
            end
            pr = 67'sd2 * x * y;
            if (pr > mx) begin pr = mx; r.sat = 1; end
            if (pr < mn) begin pr = mn; r.sat = 1; end
            lv = pr[63:0];
            if (es == 16) lv = lv & 64'h0000_0000_FFFF_FFFF;
            r.data = r.data | (128'(lv) << (e*2*es));
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Driver: called at a falling edge; returns at the falling edge after acceptance.
    task automatic send(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                        input logic uh, input logic h, input logic md, input logic lo,
                        input logic [3:0] rl, input logic sc, input logic clr, input string tag);
        exp_t e;
        op_a = a; op_b = b; size_sel = sz; upper_half = uh; idx_hi = h; idx_mid = md;
        idx_lo = lo; breg_lo = rl; scalar_mode = sc; sat_clear = clr; in_valid = 1;
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        e = model(a, b, sz, uh, h, md, lo, rl, sc);
        flag_m = e.sat ? 1'b1 : (clr ? 1'b0 : flag_m);
        e.flag = flag_m;
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
        in_valid = 0; sat_clear = 0;
    endtask

    // Monitor: compares each result in the cycle it leaves the unit.
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (q.size() == 0) begin
                check(0, "R9", "unexpected result", out_data, '0);
            end else begin
                e = q.pop_front();
                check(out_data === e.data, e.tag, "data", out_data, e.data);
                check(out_reg === e.rn, e.tag, "register number", 128'(out_reg), 128'(e.rn));
                check(out_undef === e.undef, e.tag, "undef", 128'(out_undef), 128'(e.undef));
                check(sat_flag === e.flag, e.tag, "flag (R8)", 128'(sat_flag), 128'(e.flag));
            end
        end
    end

    function automatic logic [127:0] r128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [127:0] held;
        logic [127:0] a, b;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R10: reset state
        check(out_valid === 0, "R10", "out_valid", 128'(out_valid), 0);
        check(sat_flag === 0, "R10", "sat_flag", 128'(sat_flag), 0);
        check(in_ready === 1, "R10", "in_ready", 128'(in_ready), 1);
        rst_n = 1;
        @(negedge clk);

        // R2 / R4: every 16-bit index, both halves
        for (int i = 0; i < 8; i++)
            for (int hf = 0; hf < 2; hf++)
                send(r128(), r128(), 2'b01, hf[0], i[2], i[1], i[0], 4'(i+9), 0, 0, "R2");
        // R3 / R4: every 32-bit index, both halves, both bank bits
        for (int i = 0; i < 4; i++)
            for (int hf = 0; hf < 2; hf++)
                for (int bk = 0; bk < 2; bk++)
                    send(r128(), r128(), 2'b10, hf[0], i[1], i[0], bk[0], 4'(i*3), 0, 0, "R3");

        // R6: min*min in one lane, 16-bit upper half and 32-bit lower half
        a = r128(); a[96 +: 16] = 16'h8000; b = r128(); b[5*16 +: 16] = 16'h8000;
        send(a, b, 2'b01, 1, 1, 0, 1, 4'd2, 0, 0, "R6");
        a = r128(); a[32 +: 32] = 32'h8000_0000; b = r128(); b[2*32 +: 32] = 32'h8000_0000;
        send(a, b, 2'b10, 0, 1, 0, 0, 4'd7, 0, 0, "R6");

        // R1: reserved sizes leave the flag set and produce nothing
        send(r128(), r128(), 2'b00, 0, 1, 1, 1, 4'd5, 0, 0, "R1");
        send(r128(), r128(), 2'b11, 1, 0, 1, 1, 4'd3, 1, 0, "R1");

        // R8: clear with non-saturating op clears; clear with saturating op keeps set
        send(128'h0003_0002_0001_0004, 128'h5, 2'b01, 0, 0, 0, 0, 4'd1, 0, 1, "R8");
        a = '0; a[15:0] = 16'h8000; b = '0; b[15:0] = 16'h8000;
        send(a, b, 2'b01, 0, 0, 0, 0, 4'd1, 0, 1, "R8");
        send(128'h7, 128'h9, 2'b01, 0, 0, 0, 0, 4'd1, 0, 0, "R8");
        // R8: standalone clear pulse while idle
        repeat (2) @(negedge clk);
        sat_clear = 1; @(negedge clk); sat_clear = 0; flag_m = 0; #1;
        check(sat_flag === 0, "R8", "flag after clear", 128'(sat_flag), 0);

        // R7: scalar mode ignores upper_half and upper lanes
        a = r128(); b = r128();
        send(a, b, 2'b01, 1, 0, 1, 1, 4'd4, 1, 0, "R7");
        send(a, b, 2'b10, 1, 1, 1, 1, 4'd4, 1, 0, "R7");
        a = r128(); a[31:0] = 32'h8000_0000; b = r128(); b[127:96] = 32'h8000_0000;
        send(a, b, 2'b10, 1, 1, 1, 0, 4'd0, 1, 0, "R7");

        // R9: stall holds the output and blocks input
        repeat (2) @(negedge clk);
        out_ready = 0;
        send(r128(), r128(), 2'b01, 0, 1, 1, 0, 4'd6, 0, 0, "R9");
        #1 held = out_data;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid === 1, "R9", "valid held", 128'(out_valid), 1);
        check(out_data === held, "R9", "data held", out_data, held);
        check(in_ready === 0, "R9", "in_ready low", 128'(in_ready), 0);
        @(negedge clk);
        out_ready = 1;

        // R5: random operations
        for (int k = 0; k < 300; k++) begin
            logic [31:0] s = $urandom;
            send(r128(), r128(), (s[0] ? 2'b10 : 2'b01), s[1], s[2], s[3], s[4],
                 s[8:5], s[9] & s[10], 0, "R5");
        end

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R9", "results outstanding", 128'(q.size()), 0);
        done = 1;
        summary();
    end
endmodule